// File: doc/BRIEF.md
# Protected-Register Unlock Key Detector

This block guards the write enables of the protected control fields of a controller, such as the programming-go bit, the programming enable, the boot selector and the update-enable bits. It watches the write side of a register bus. Protection opens only after the exact byte key 0x59, 0x16, 0x88 has been written in that order to a single key address. That address sits at offset 0x100 of the system-control window.

The key is tracked by a four-state sequencer. A byte that does not fit the sequence sends the sequencer back to its start, except that 0x59 is always taken as a fresh first key byte. While protection is open, a write of any byte other than 0x59 to the key address closes it again. Writes to other addresses are ignored.

The open/closed status is readable at the key address. Each field write request from the controller is passed through only while protection is open.

Top module: `wprot_unlock`

## Requirements
- R1: After reset the block is locked: `unlocked` is 0, every `prot_we_out` bit is 0 and a read of the key address returns 0.
- R2: Writing 0x59, then 0x16, then 0x88 to address `PROT_ADDR` (default 0x100) unlocks the block. `unlocked` goes to 1 in the cycle after the clock edge that captures the third write.
- R3: While locked, a write to the key address of a byte that is neither the next key byte nor 0x59 returns the sequence to its start. A later attempt then needs all three key bytes again.
- R4: While locked, a write of 0x59 at any point of the sequence makes it the first key byte. The sequence 0x59, 0x59, 0x16, 0x88 therefore unlocks.
- R5: Bus writes to any address other than `PROT_ADDR`, and cycles with `bus_wr` low, do not change the progress of the key or the lock state.
- R6: While unlocked, a write to the key address of any byte other than 0x59 relocks the block in the next cycle. A write of 0x59 leaves it unlocked.
- R7: A read with `bus_raddr` equal to `PROT_ADDR` returns `unlocked` in bit 0 and 0 in every other bit. A read of any other address returns 0. The read path is combinational.
- R8: Each `prot_we_out[i]` equals `prot_we_in[i]` while unlocked and is 0 while locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_waddr | input | ADDR_W | Write byte address |
| bus_wdata | input | 8 | Low byte lane of the write data |
| bus_raddr | input | ADDR_W | Read byte address |
| bus_rdata | output | DATA_W | Read data (status word) |
| prot_we_in | input | NUM_PROT | Write requests for the protected fields |
| prot_we_out | output | NUM_PROT | Gated write enables for the protected fields |
| unlocked | output | 1 | 1 while protected writes are allowed |

## Verification
The bench aims at the restart corners. If a wrong byte were treated as a simple stall, a foreign byte followed by 0x16, 0x88 would wrongly unlock. If a repeated 0x59 were treated as an error, a retried key would fail to unlock. Interleaved writes to neighbouring addresses check that address decoding is exact: a loose decode would abort the key or relock the block. In the unlocked state, 0x59 and other bytes are written to confirm that only a non-0x59 byte relocks, and that gating and status follow in the same cycle as `unlocked`.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

  localparam logic [7:0] KEY_B0 = 8'h59;
  localparam logic [7:0] KEY_B1 = 8'h16;
  localparam logic [7:0] KEY_B2 = 8'h88;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_K1   = 2'd1,
    ST_K2   = 2'd2,
    ST_OPEN = 2'd3
  } key_st_t;

  // Next key state for one byte written to the key address.
  function automatic key_st_t key_next(input key_st_t cur, input logic [7:0] b);
    key_st_t nxt;
    case (cur)
      ST_OPEN: nxt = (b == KEY_B0) ? ST_OPEN : ST_IDLE;
      ST_K1:   nxt = (b == KEY_B1) ? ST_K2 : ((b == KEY_B0) ? ST_K1 : ST_IDLE);
      ST_K2:   nxt = (b == KEY_B2) ? ST_OPEN : ((b == KEY_B0) ? ST_K1 : ST_IDLE);
      default: nxt = (b == KEY_B0) ? ST_K1 : ST_IDLE;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/wprot_wr_decode.sv
module wprot_wr_decode #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] PROT_ADDR = 'h100
) (
  input  logic              wr,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  output logic              key_hit,
  output logic [7:0]        key_byte
);
  always_comb begin
    key_hit  = wr && (waddr == PROT_ADDR);
    key_byte = wdata;
  end
endmodule

// File: rtl/wprot_seq.sv
module wprot_seq
  import wprot_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_hit,
  input  logic [7:0] key_byte,
  output logic       unlocked
);
  key_st_t st, st_nxt;

  always_comb begin
    st_nxt = st;
    if (key_hit) st_nxt = key_next(st, key_byte);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nxt;
  end

  assign unlocked = (st == ST_OPEN);

  // R2
  unlock_after_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(key_hit && key_byte == KEY_B2 && st == ST_K2));

  // R5
  no_hit_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !key_hit |=> $stable(st));

  // R6
  relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && key_hit && key_byte != KEY_B0) |=> !unlocked);

  // R4
  first_byte_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && key_hit && key_byte == KEY_B0) |=> (st == ST_K1));
endmodule

// File: rtl/wprot_rd_port.sv
module wprot_rd_port #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] PROT_ADDR = 'h100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] raddr,
  input  logic              unlocked,
  output logic [DATA_W-1:0] rdata
);
  always_comb begin
    rdata = '0;
    if (raddr == PROT_ADDR) rdata[0] = unlocked;
  end

  // R7
  rd_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[DATA_W-1:1] == '0);
endmodule

// File: rtl/wprot_gate.sv
module wprot_gate #(
  parameter int NUM_PROT = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                unlocked,
  input  logic [NUM_PROT-1:0] we_in,
  output logic [NUM_PROT-1:0] we_out
);
  for (genvar i = 0; i < NUM_PROT; i++) begin : g_lane
    assign we_out[i] = we_in[i] & unlocked;
  end

  // R8
  locked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |-> (we_out == '0));
endmodule

// File: rtl/wprot_unlock.sv
module wprot_unlock #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int NUM_PROT = 8,
  parameter logic [ADDR_W-1:0] PROT_ADDR = 'h100
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_waddr,
  input  logic [7:0]          bus_wdata,
  input  logic [ADDR_W-1:0]   bus_raddr,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NUM_PROT-1:0] prot_we_in,
  output logic [NUM_PROT-1:0] prot_we_out,
  output logic                unlocked
);
  logic       key_hit;
  logic [7:0] key_byte;

  wprot_wr_decode #(.ADDR_W(ADDR_W), .PROT_ADDR(PROT_ADDR)) u_dec (
    .wr(bus_wr), .waddr(bus_waddr), .wdata(bus_wdata),
    .key_hit(key_hit), .key_byte(key_byte)
  );

  wprot_seq u_seq (
    .clk(clk), .rst_n(rst_n), .key_hit(key_hit), .key_byte(key_byte),
    .unlocked(unlocked)
  );

  wprot_rd_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROT_ADDR(PROT_ADDR)) u_rd (
    .clk(clk), .rst_n(rst_n), .raddr(bus_raddr), .unlocked(unlocked),
    .rdata(bus_rdata)
  );

  wprot_gate #(.NUM_PROT(NUM_PROT)) u_gate (
    .clk(clk), .rst_n(rst_n), .unlocked(unlocked),
    .we_in(prot_we_in), .we_out(prot_we_out)
  );
endmodule

// File: tb/sim_wprot_unlock.sv
module sim_wprot_unlock;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int NUM_PROT = 8;
  localparam logic [ADDR_W-1:0] KADDR = 12'h100;

  logic clk = 0;
  logic rst_n = 0;
  logic bus_wr = 0;
  logic [ADDR_W-1:0] bus_waddr = '0;
  logic [7:0] bus_wdata = '0;
  logic [ADDR_W-1:0] bus_raddr = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic [NUM_PROT-1:0] prot_we_in = '0;
  logic [NUM_PROT-1:0] prot_we_out;
  logic unlocked;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  bit running = 0;

  // Reference model: the recent key-address bytes since the last lock change.
  bit exp_unl = 0;
  byte unsigned hist[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  wprot_unlock #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_PROT(NUM_PROT), .PROT_ADDR(KADDR)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_waddr(bus_waddr),
    .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata),
    .prot_we_in(prot_we_in), .prot_we_out(prot_we_out), .unlocked(unlocked)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic void model_write(input logic [ADDR_W-1:0] a, input byte unsigned b);
    if (a != KADDR) return;
    if (exp_unl) begin
      if (b != 8'h59) begin exp_unl = 0; hist.delete(); end
    end else begin
      hist.push_back(b);
      if (hist.size() > 3) void'(hist.pop_front());
      if (hist.size() == 3 && hist[0] == 8'h59 && hist[1] == 8'h16 && hist[2] == 8'h88) begin
        exp_unl = 1;
        hist.delete();
      end
    end
  endfunction

  // Per-cycle comparison against the model.
  always @(negedge clk) begin
    if (running) begin
      chk("R2 unlocked", unlocked, exp_unl);
      chk("R7 rdata", bus_rdata, (bus_raddr == KADDR) ? DATA_W'(exp_unl) : '0);
      chk("R8 we_out", prot_we_out, exp_unl ? prot_we_in : '0);
    end
  end

  task automatic cyc(input bit wr, input logic [ADDR_W-1:0] a, input byte unsigned b);
    @(negedge clk); #1;
    bus_wr = wr; bus_waddr = a; bus_wdata = b;
    bus_raddr = ($urandom_range(0, 2) == 0) ? 12'h104 : KADDR;
    prot_we_in = NUM_PROT'($urandom);
    @(posedge clk);
    if (wr) model_write(a, b);
    #1 bus_wr = 0;
  endtask

  task automatic wk(input byte unsigned b); cyc(1, KADDR, b); endtask

  task automatic expect_lock(input string req, input bit e);
    @(negedge clk);
    chk(req, unlocked, e);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; failures++;
    $display("FAIL watchdog actual=running expected=finished");
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    end
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    bus_raddr = KADDR; prot_we_in = '1; #1;
    chk("R1 unlocked", unlocked, 0);
    chk("R1 rdata", bus_rdata, 0);
    chk("R1 we_out", prot_we_out, 0);
    rst_n = 1;
    running = 1;

    // R2: plain key
    wk(8'h59); wk(8'h16); wk(8'h88);
    expect_lock("R2 key unlocks", 1);
    // R6: 0x59 keeps open, other byte relocks
    wk(8'h59);
    expect_lock("R6 0x59 stays open", 1);
    wk(8'h00);
    expect_lock("R6 relock", 0);

    // R3: foreign byte mid-key restarts
    wk(8'h59); wk(8'h33); wk(8'h16); wk(8'h88);
    expect_lock("R3 restart after wrong byte", 0);
    wk(8'h59); wk(8'h16); wk(8'h16); wk(8'h88);
    expect_lock("R3 repeated second byte", 0);

    // R4: 0x59 resumes as first byte
    wk(8'h59); wk(8'h59); wk(8'h16); wk(8'h88);
    expect_lock("R4 repeated first byte unlocks", 1);
    wk(8'h88);
    expect_lock("R6 relock with key byte", 0);
    wk(8'h59); wk(8'h16); wk(8'h59); wk(8'h16); wk(8'h88);
    expect_lock("R4 0x59 in third slot", 1);
    wk(8'h16);
    expect_lock("R6 relock 0x16", 0);

    // R5: other addresses and idle cycles leave the key intact
    wk(8'h59); cyc(1, 12'h101, 8'h00); cyc(0, KADDR, 8'h00);
    wk(8'h16); cyc(1, 12'h000, 8'h33); cyc(1, 12'h900, 8'h22);
    wk(8'h88);
    expect_lock("R5 interleaved writes", 1);
    cyc(1, 12'h0FF, 8'h00); cyc(0, KADDR, 8'h11);
    expect_lock("R5 open unaffected", 1);
    wk(8'hFF);
    expect_lock("R6 relock 0xFF", 0);

    // Random stream
    for (int i = 0; i < 400; i++) begin
      int r;
      byte unsigned b;
      r = $urandom_range(0, 9);
      case ($urandom_range(0, 3))
        0: b = 8'h59; 1: b = 8'h16; 2: b = 8'h88; default: b = 8'($urandom);
      endcase
      if (r < 7) wk(b);
      else if (r < 9) cyc(1, 12'h100 ^ 12'(1 << $urandom_range(0, 11)), b);
      else cyc(0, KADDR, b);
    end

    // R7: other read address returns zero while open
    wk(8'h00); wk(8'h59); wk(8'h16); wk(8'h88);
    @(negedge clk); #1 bus_raddr = 12'h104; #1;
    chk("R7 other address", bus_rdata, 0);
    bus_raddr = KADDR; #1;
    chk("R7 status bit", bus_rdata, 1);

    running = 0;
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    end
    $finish;
  end
endmodule